// File: doc/BRIEF.md
# Interleaved Dual-Ramp PWM Timer

This block is an up-counting, single-slope PWM timer with a parameterised number of compare channels (two or four). In plain mode it produces ordinary edge-aligned PWM on every channel. In its three dual-ramp modes the counter alternates between two consecutive cycles, ramp A and ramp B. Ramp A allows only the even-numbered outputs to be active, and ramp B allows only the odd-numbered ones. This gives the interleaved drive needed by half-bridge, push-pull and power-factor-correction stages.

The dual-ramp variants differ in where each ramp takes its length and compare values from. The standard variant can alternate between two period values held in a circular pair. The alternate variant drives outputs 0 and 1 from compare channel 0 alone. The critical variant ends ramp A on compare channel 0 and ramp B on the period value, so no circular pair is needed. A two-bit ramp-index command lets software force or step the ramp index at the next wrap.

All pins are plain control and status signals. There is no data stream, so the block has no valid/ready handshake and applies no back-pressure. The counter runs on every clock cycle once reset is released.

Top module: `dpwm_top`

## Requirements
- R1: After reset the count is 0, the ramp index is A (0), no index command is pending and the circular slot is 0, so the outputs reflect count 0 during ramp A.
- R2: The count rises by one per clock. On a cycle where the count is greater than or equal to the active top, an update occurs and the count returns to 0 on the next cycle.
- R3: In mode 0 (plain), every output i equals pol[i] XOR (count < compare i). The ramp index has no effect on the outputs, the circular setting has no effect on them, and the active top is the period input.
- R4: With no pending command, the ramp index (0 = A, 1 = B) inverts at every update and holds its value between updates.
- R5: In modes 1, 2 and 3, an odd-numbered output is forced to its inactive level (its polarity bit) while the index is A, and an even-numbered output is forced inactive while the index is B.
- R6: In mode 1 (standard), each output follows the R3 rule gated by R5. The active top is the period input, or the alternate period when the circular enable is set and the slot is 1. While the circular enable is set, the slot inverts at every update, in every mode.
- R7: In mode 2 (alternate), outputs 0 and 1 both use compare 0, or the alternate compare 0 when the circular enable is set and the slot is 1, together with polarity bit 0. Compare 1 and polarity bit 1 are ignored. The top follows R6, and R5 gating applies.
- R8: In mode 3 (critical), the active top is compare 0 during ramp A and the period input during ramp B, whatever the circular setting.
- R9: In mode 3 with four channels, output 0 is active during ramp A while compare 2 <= count < compare 0. With two channels it is active for the whole of ramp A. Polarity bit 0 inverts it. The other outputs follow the R3 rule gated by R5.
- R10: The index command encodings are 0 none, 1 set A, 2 set B and 3 toggle. A non-zero command is latched and applied at the next update, and a later command overwrites an earlier one that is still pending. Toggle inverts the automatic step, so the index repeats. A command presented on an update cycle waits for the following update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 plain, 1 standard, 2 alternate, 3 critical |
| cir_en | input | 1 | Circular period and compare pair enable |
| period | input | CNT_W | Primary period value |
| period_alt | input | CNT_W | Second entry of the circular period pair |
| cmp_val | input | NUM_CH*CNT_W | Compare values, channel i at bits i*CNT_W |
| cmp0_alt | input | CNT_W | Second entry of the circular compare-0 pair |
| pol | input | NUM_CH | Per-channel polarity, 1 inverts the output |
| idx_cmd | input | 2 | Ramp index command, applied at the next update |
| wave | output | NUM_CH | Waveform outputs |
| ramp_idx | output | 1 | Current ramp index, 0 = A, 1 = B |

## Verification
The bench targets four corner cases.

- **Commands near a wrap.** Commands land exactly on an update cycle, and a later command overwrites a pending one. A design that applied commands at once, or that dropped the newer one, would leave the ramp index out of step for a whole ramp.
- **Top smaller than the count.** Periods and compares are changed to values below the running count, and zero is used as a top. A counter that tested for equality instead of greater-or-equal would run on to the full counter range.
- **Circular slot versus ramp index.** A toggle command is combined with the circular enable, which pulls the slot and the index apart. A design that used the index to choose the period would then pick the wrong entry of the pair.
- **Critical output 0 in both builds.** Output 0 in critical mode is checked in the four-channel and the two-channel build. A design that mixed the two up would either miss the compare-2 set point or cut the pulse short before the end of ramp A.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_STD   = 2'd1,
    MODE_ALT   = 2'd2,
    MODE_CRIT  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_SET_A  = 2'd1,
    CMD_SET_B  = 2'd2,
    CMD_TOGGLE = 2'd3
  } cmd_e;
endpackage

// File: rtl/dpwm_ramp_ctrl.sv
module dpwm_ramp_ctrl
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             cir_en,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] period_alt,
  input  logic [CNT_W-1:0] cmp0,
  input  cmd_e             idx_cmd,
  output logic [CNT_W-1:0] cnt,
  output logic             idx,
  output logic             slot
);
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] slot_per;
  logic             update;
  logic             idx_next;
  cmd_e             pend;

  // Period for the modes that use the circular pair.
  assign slot_per = (cir_en && slot) ? period_alt : period;

  // Active top for the current ramp.
  always_comb begin
    unique case (mode)
      MODE_PLAIN: top = period;
      MODE_STD,
      MODE_ALT:   top = slot_per;
      MODE_CRIT:  top = idx ? period : cmp0;
      default:    top = period;
    endcase
  end

  // A top moved below the running count still ends the ramp.
  assign update = (cnt >= top);

  // Index for the next ramp.
  always_comb begin
    unique case (pend)
      CMD_NONE:   idx_next = ~idx;
      CMD_SET_A:  idx_next = 1'b0;
      CMD_SET_B:  idx_next = 1'b1;
      CMD_TOGGLE: idx_next = idx;
      default:    idx_next = ~idx;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      idx  <= 1'b0;
      slot <= 1'b0;
      pend <= CMD_NONE;
    end else begin
      if (update) begin
        cnt  <= '0;
        idx  <= idx_next;
        slot <= slot ^ cir_en;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (idx_cmd != CMD_NONE) pend <= idx_cmd;
      else if (update)         pend <= CMD_NONE;
    end
  end

  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (cnt == '0));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> (cnt == $past(cnt) + 1'b1));
  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(idx));
  p_auto_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (update && pend == CMD_NONE) |=> (idx != $past(idx)));
  p_cmd_set_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (update && pend == CMD_SET_B) |=> idx);
  p_cmd_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (update && pend == CMD_TOGGLE) |=> $stable(idx));
  p_slot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!update || !cir_en) |=> $stable(slot));
endmodule

// File: rtl/dpwm_wave.sv
module dpwm_wave
  import dpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  mode_e                   mode,
  input  logic [CNT_W-1:0]        cnt,
  input  logic                    idx,
  input  logic                    slot,
  input  logic                    cir_en,
  input  logic [NUM_CH*CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0]        cmp0_alt,
  input  logic [NUM_CH-1:0]       pol,
  output logic [NUM_CH-1:0]       wave
);
  logic             dual;
  logic [CNT_W-1:0] cmp0_eff;

  assign dual     = (mode != MODE_PLAIN);
  assign cmp0_eff = (cir_en && slot) ? cmp0_alt : cmp_val[0 +: CNT_W];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam bit ODD = (ch % 2) == 1;
    logic [CNT_W-1:0] c_src;
    logic             p_src;
    logic             crit_act;
    logic             raw;
    logic             gate;

    // Compare value and polarity source for this output.
    if (ch < 2) begin : g_pair
      always_comb begin
        if (mode == MODE_ALT) begin
          c_src = cmp0_eff;
          p_src = pol[0];
        end else begin
          c_src = cmp_val[ch*CNT_W +: CNT_W];
          p_src = pol[ch];
        end
      end
    end else begin : g_plain
      assign c_src = cmp_val[ch*CNT_W +: CNT_W];
      assign p_src = pol[ch];
    end

    // Set/clear window for output 0 in critical mode.
    if (ch == 0 && NUM_CH > 2) begin : g_crit_win
      assign crit_act = (cnt >= cmp_val[2*CNT_W +: CNT_W]) &&
                        (cnt <  cmp_val[0 +: CNT_W]);
    end else if (ch == 0) begin : g_crit_full
      assign crit_act = 1'b1;
    end else begin : g_crit_none
      assign crit_act = 1'b0;
    end

    always_comb begin
      if (mode == MODE_CRIT && ch == 0) raw = crit_act;
      else                               raw = (cnt < c_src);
    end

    assign gate     = dual && (ODD ? !idx : idx);
    assign wave[ch] = p_src ^ (raw && !gate);
  end

  p_odd_off_in_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STD && !idx) |-> (wave[1] == pol[1]));
  p_even_off_in_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && idx) |-> (wave[0] == pol[0]));
  p_alt_shared_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ALT && !idx) |-> (wave[1] == pol[0]));
  p_plain_ungated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PLAIN && cnt < cmp_val[CNT_W +: CNT_W]) |-> (wave[1] != pol[1]));
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic                    cir_en,
  input  logic [CNT_W-1:0]        period,
  input  logic [CNT_W-1:0]        period_alt,
  input  logic [NUM_CH*CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0]        cmp0_alt,
  input  logic [NUM_CH-1:0]       pol,
  input  logic [1:0]              idx_cmd,
  output logic [NUM_CH-1:0]       wave,
  output logic                    ramp_idx
);
  mode_e            mode_q;
  cmd_e             cmd_q;
  logic [CNT_W-1:0] cnt;
  logic             idx;
  logic             slot;

  assign mode_q = mode_e'(mode);
  assign cmd_q  = cmd_e'(idx_cmd);

  dpwm_ramp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .cir_en     (cir_en),
    .period     (period),
    .period_alt (period_alt),
    .cmp0       (cmp_val[0 +: CNT_W]),
    .idx_cmd    (cmd_q),
    .cnt        (cnt),
    .idx        (idx),
    .slot       (slot)
  );

  dpwm_wave #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .cnt      (cnt),
    .idx      (idx),
    .slot     (slot),
    .cir_en   (cir_en),
    .cmp_val  (cmp_val),
    .cmp0_alt (cmp0_alt),
    .pol      (pol),
    .wave     (wave)
  );

  assign ramp_idx = idx;
endmodule

// File: tb/dpwm_top_tb_top.sv
`timescale 1ns/1ps
module dpwm_top_tb_top;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        cir_en = 1'b0;
  logic [15:0] period = 16'd5;
  logic [15:0] period_alt = 16'd5;
  logic [63:0] cmp_val = '0;
  logic [15:0] cmp0_alt = '0;
  logic [3:0]  pol = '0;
  logic [1:0]  idx_cmd = 2'd0;
  logic [3:0]  wave4;
  logic [1:0]  wave2;
  logic        idx4, idx2;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // Bench model state
  int m_cnt  = 0;
  bit m_idx  = 0;
  bit m_slot = 0;
  int m_pend = 0;

  always #2.5 clk = ~clk;

  dpwm_top #(.CNT_W(W), .NUM_CH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cir_en(cir_en), .period(period),
    .period_alt(period_alt), .cmp_val(cmp_val), .cmp0_alt(cmp0_alt), .pol(pol),
    .idx_cmd(idx_cmd), .wave(wave4), .ramp_idx(idx4));

  dpwm_top #(.CNT_W(W), .NUM_CH(2)) dut2_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cir_en(cir_en), .period(period),
    .period_alt(period_alt), .cmp_val(cmp_val[31:0]), .cmp0_alt(cmp0_alt),
    .pol(pol[1:0]), .idx_cmd(idx_cmd), .wave(wave2), .ramp_idx(idx2));

  // Expected outputs from the requirements (R3, R5, R6, R7, R9)
  function automatic logic [3:0] exp_wave(int nch);
    logic [3:0] r = '0;
    for (int ch = 0; ch < nch; ch++) begin
      int c = int'(cmp_val[ch*16 +: 16]);
      bit p = pol[ch];
      bit act;
      if (mode == 2'd2 && ch < 2) begin
        c = (cir_en && m_slot) ? int'(cmp0_alt) : int'(cmp_val[15:0]);
        p = pol[0];
      end
      act = (m_cnt < c);
      if (mode == 2'd3 && ch == 0)
        act = (nch > 2) ? (m_cnt >= int'(cmp_val[47:32]) && m_cnt < int'(cmp_val[15:0])) : 1'b1;
      if (mode != 2'd0 && (((ch % 2) == 1 && !m_idx) || ((ch % 2) == 0 && m_idx))) act = 1'b0;
      r[ch] = p ^ act;
    end
    return r;
  endfunction

  // Active top from R3, R6, R8
  function automatic int exp_top();
    case (mode)
      2'd0: return int'(period);
      2'd1, 2'd2: return (cir_en && m_slot) ? int'(period_alt) : int'(period);
      default: return m_idx ? int'(period) : int'(cmp_val[15:0]);
    endcase
  endfunction

  // Next model state from R2, R4, R6, R10
  task automatic model_advance();
    bit upd = (m_cnt >= exp_top());
    int old_pend = m_pend;
    if (idx_cmd != 2'd0) m_pend = int'(idx_cmd);
    else if (upd)        m_pend = 0;
    if (upd) begin
      m_cnt = 0;
      case (old_pend)
        1: m_idx = 1'b0;
        2: m_idx = 1'b1;
        3: m_idx = m_idx;
        default: m_idx = ~m_idx;
      endcase
      m_slot = m_slot ^ cir_en;
    end else begin
      m_cnt = m_cnt + 1;
    end
  endtask

  task automatic check(string tag);
    logic [3:0] e4 = exp_wave(4);
    logic [3:0] e2 = exp_wave(2);
    tests++;
    if (idx4 !== m_idx || idx2 !== m_idx) begin
      fails++;
      $display("FAIL %s ramp index: got %0b/%0b expected %0b (mode %0d)", tag, idx4, idx2, m_idx, mode);
    end
    tests++;
    if (wave4 !== e4) begin
      fails++;
      $display("FAIL %s wave 4ch: got %b expected %b (mode %0d cnt %0d)", tag, wave4, e4, mode, m_cnt);
    end
    tests++;
    if (wave2 !== e2[1:0]) begin
      fails++;
      $display("FAIL %s wave 2ch: got %b expected %b (mode %0d cnt %0d)", tag, wave2, e2[1:0], mode, m_cnt);
    end
  endtask

  task automatic tick(string tag);
    model_advance();
    @(negedge clk);
    check(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  function automatic string mode_tag();
    case (mode)
      2'd0: return "R3";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R9";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    cmp_val = {16'd2, 16'd4, 16'd3, 16'd2};
    pol = 4'b0000;
    repeat (3) @(negedge clk);
    check("R1");                 // R1 during reset
    rst_n = 1'b1;
    check("R1");                 // R1 right after release

    // R2: plain counting and wrap at top
    mode = 2'd0; period = 16'd4;
    run(15, "R2");
    // R2: top dropped below the running count
    period = 16'd9; run(7, "R2"); period = 16'd2; run(6, "R2");
    // R2: zero top, update every cycle
    period = 16'd0; run(4, "R2");

    // R3: plain with polarity mix
    period = 16'd6; pol = 4'b1010; run(16, "R3");

    // R4: standard, index alternates
    mode = 2'd1; pol = 4'b0000; period = 16'd3; run(16, "R4");

    // R5: compares above the period, only gating shapes the outputs
    cmp_val = {16'd50, 16'd50, 16'd50, 16'd50}; run(16, "R5");
    pol = 4'b0110; run(12, "R5");

    // R10: each command, and overwrite of a pending one
    pol = 4'b0000; cmp_val = {16'd1, 16'd2, 16'd1, 16'd2};
    idx_cmd = 2'd2; tick("R10"); idx_cmd = 2'd0; run(8, "R10");
    idx_cmd = 2'd1; tick("R10"); idx_cmd = 2'd0; run(8, "R10");
    idx_cmd = 2'd3; tick("R10"); idx_cmd = 2'd0; run(8, "R10");
    idx_cmd = 2'd2; tick("R10"); idx_cmd = 2'd1; tick("R10"); idx_cmd = 2'd0; run(8, "R10");

    // R6: circular period pair, with toggle to separate slot from index
    cir_en = 1'b1; period = 16'd3; period_alt = 16'd7; run(24, "R6");
    idx_cmd = 2'd3; tick("R6"); idx_cmd = 2'd0; run(24, "R6");

    // R7: alternate with circular compare pair
    mode = 2'd2; cmp_val = {16'd2, 16'd1, 16'd6, 16'd2}; cmp0_alt = 16'd5;
    pol = 4'b0001; run(30, "R7");
    cir_en = 1'b0; run(20, "R7");

    // R8: critical, ramp A ends at compare 0, ramp B at period
    mode = 2'd3; cir_en = 1'b1; period = 16'd8; period_alt = 16'd2;
    cmp_val = {16'd1, 16'd2, 16'd3, 16'd4}; pol = 4'b0000; run(30, "R8");

    // R9: critical output 0 window and two-channel full pulse
    cmp_val = {16'd3, 16'd2, 16'd5, 16'd6}; run(30, "R9");
    pol = 4'b0001; run(20, "R9");

    // Random phase
    for (int blk = 0; blk < 100; blk++) begin
      mode       = 2'($urandom_range(0, 3));
      cir_en     = 1'($urandom_range(0, 1));
      period     = 16'($urandom_range(0, 12));
      period_alt = 16'($urandom_range(0, 12));
      cmp0_alt   = 16'($urandom_range(0, 14));
      pol        = 4'($urandom_range(0, 15));
      for (int ch = 0; ch < 4; ch++) cmp_val[ch*16 +: 16] = 16'($urandom_range(0, 14));
      for (int i = 0; i < 37; i++) begin
        idx_cmd = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
        tick(mode_tag());
      end
      idx_cmd = 2'd0;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule